// File: doc/BRIEF.md
# Palette Colour Table Host Port

This block holds a 256-entry colour lookup table of red, green and blue bytes. It also provides the host register word through which software loads and inspects the table. The host sees one 32-bit word split into four byte lanes. A write strobe with byte enables updates any subset of the lanes. A read strobe returns the whole word one clock later.

A colour entry travels as three consecutive byte accesses on the single data lane, in the order red, green, blue. A shared component counter tracks which colour comes next. After the third byte, the write index or the read index steps on by itself, so software can stream a whole table with one index setup. Written bytes are filtered by a pixel mask held in its own lane.

A second, independent read port lets the display path look up one pixel colour per clock.

Top module: `pal_dac_port`

## Requirements
- R1: After reset, the write index, read index and component counter are zero, the mask is all ones, and `host_rdata` is zero.
- R2: Lane positions in `host_wdata` and `host_rdata` are as follows. Bits [7:0] hold the write index, [15:8] the colour data, [23:16] the pixel mask and [31:24] the read index. A write updates only the lanes whose `host_be` bit is set.
- R3: A write to either index lane clears the component counter. A data lane enabled in the same access is ignored.
- R4: Each data write stores the data byte ANDed with the mask into the holding slot picked by the counter (0 red, 1 green, 2 blue), then advances the counter. The mask used is the one held before the access, even when the same access rewrites the mask.
- R5: The third data write commits {red, green, blue} to the entry at the write index, with red in bits [23:16] and blue in [7:0]. It then increments the write index and clears the counter.
- R6: A read with the counter at zero first fetches all three components of the entry at the read index. Each read returns the component picked by the counter in bits [15:8] of `host_rdata`, one clock after the strobe. The third read increments the read index and clears the counter.
- R7: A read returns the write index, mask and read index in their lanes, as they stood before that access.
- R8: Both indices wrap from 255 to 0.
- R9: `pix_color` shows the entry at the `pix_index` value sampled at the previous clock edge. A commit at that same edge is not yet visible.
- R10: When both strobes are high, only the write takes effect and `host_rdata` holds. With no strobe, `host_rdata`, the indices and the counter hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_be | input | 4 | Byte enables for a write |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word, valid the clock after a read |
| pix_index | input | 8 | Display lookup address |
| pix_color | output | 24 | Display lookup result {R,G,B} |

## Verification
A host read produces its word at the clock edge that samples the strobe. The bench therefore drives each access just after a falling edge and samples `host_rdata` at the next falling edge, half a period after the result register loads. A pixel lookup also takes one register, so `pix_color` is compared at the falling edge following the edge that sampled `pix_index`. The same-edge commit case is looked at both at that falling edge and one clock later. A behavioural model advances on every rising edge and is compared against both outputs at every falling edge, alongside directed checks with hand-computed words.

// File: rtl/pal_dac_pkg.sv
// Shared constants for the palette colour table port.
// Assumes the host word is four lanes of equal width.
package pal_dac_pkg;
    localparam int NUM_LANES = 4;
    localparam int LANE_WIDX = 0;   // write index lane
    localparam int LANE_DATA = 1;   // colour data lane
    localparam int LANE_MASK = 2;   // pixel mask lane
    localparam int LANE_RIDX = 3;   // read index lane

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;
endpackage

// File: rtl/pal_ram.sv
// Colour table storage: one write port, one combinational fetch port for the
// host sequencer, and one registered lookup port for the display path.
// Assumes the contents need no reset; only the lookup register is cleared.
module pal_ram #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] fetch_addr,
    output logic [ENT_W-1:0] fetch_data,
    input  logic [IDX_W-1:0] look_addr,
    output logic [ENT_W-1:0] look_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    // Store a committed entry.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign fetch_data = mem[fetch_addr];

    // Registered display lookup, read before any same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n) look_data <= '0;
        else        look_data <= mem[look_addr];
    end
endmodule

// File: rtl/pal_seq.sv
// Host access sequencer: decodes byte lanes, keeps the write and read indices,
// the mask, the shared component counter and the holding slots, and builds the
// registered read word. Assumes IDX_W <= COMP_W so an index fits in a lane.
module pal_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int NCOMP  = 3,
    parameter int ENT_W  = COMP_W * NCOMP,
    parameter int BUS_W  = NUM_LANES * COMP_W,
    parameter int CNT_W  = $clog2(NCOMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_re,
    input  logic [NUM_LANES-1:0] host_be,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic             commit_en,
    output logic [ENT_W-1:0] commit_data,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [ENT_W-1:0] fetch_data,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NCOMP - 1);

    logic [COMP_W-1:0] lane [NUM_LANES];
    logic [COMP_W-1:0] hold [NCOMP];
    logic [COMP_W-1:0] fetch_comp [NCOMP];
    logic [COMP_W-1:0] mask;
    logic [COMP_W-1:0] masked;
    logic [COMP_W-1:0] rd_byte;
    logic set_w, set_r, set_m, data_wr, data_rd, last;

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LANES; gl++) begin : g_lane
            assign lane[gl] = host_wdata[gl*COMP_W +: COMP_W];
        end
        for (gl = 0; gl < NCOMP; gl++) begin : g_comp
            // Component 0 sits in the most significant slot of an entry.
            assign fetch_comp[gl] = fetch_data[(NCOMP-1-gl)*COMP_W +: COMP_W];
            if (gl == NCOMP - 1) begin : g_tail
                assign commit_data[(NCOMP-1-gl)*COMP_W +: COMP_W] = masked;
            end else begin : g_held
                assign commit_data[(NCOMP-1-gl)*COMP_W +: COMP_W] = hold[gl];
            end
        end
    endgenerate

    assign set_w   = host_we && host_be[LANE_WIDX];
    assign set_r   = host_we && host_be[LANE_RIDX];
    assign set_m   = host_we && host_be[LANE_MASK];
    assign data_wr = host_we && host_be[LANE_DATA] && !set_w && !set_r;
    assign data_rd = host_re && !host_we;
    assign last    = (cnt == LAST);
    assign masked  = lane[LANE_DATA] & mask;
    assign commit_en = data_wr && last;
    assign rd_byte = (cnt == '0) ? fetch_comp[0] : hold[cnt];

    // Indices and the shared component counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt    <= '0;
        end else if (set_w || set_r) begin
            if (set_w) wr_idx <= lane[LANE_WIDX][IDX_W-1:0];
            if (set_r) rd_idx <= lane[LANE_RIDX][IDX_W-1:0];
            cnt <= '0;
        end else if (data_wr) begin
            if (last) begin
                wr_idx <= wr_idx + 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (data_rd) begin
            if (last) begin
                rd_idx <= rd_idx + 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Pixel mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask <= '1;
        else if (set_m) mask <= lane[LANE_MASK];
    end

    // Holding slots: filled by data writes or by a fetch on the first read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCOMP; k++) hold[k] <= '0;
        end else if (data_wr) begin
            hold[cnt] <= masked;
        end else if (data_rd && cnt == '0) begin
            for (int k = 0; k < NCOMP; k++) hold[k] <= fetch_comp[k];
        end
    end

    // Read word register, loaded only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (data_rd) begin
            host_rdata <= {COMP_W'(rd_idx), mask, rd_byte, COMP_W'(wr_idx)};
        end
    end
endmodule

// File: rtl/pal_dac_port.sv
// Top of the palette colour table port: host sequencer plus table storage
// with an independent display lookup port. Assumes one clock domain.
module pal_dac_port
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int NCOMP  = 3,
    parameter int ENT_W  = COMP_W * NCOMP,
    parameter int BUS_W  = NUM_LANES * COMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_re,
    input  logic [3:0]       host_be,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    input  logic [IDX_W-1:0] pix_index,
    output logic [ENT_W-1:0] pix_color
);
    localparam int CNT_W = $clog2(NCOMP);

    logic             commit_en;
    logic [ENT_W-1:0] commit_data;
    logic [ENT_W-1:0] fetch_data;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] cnt;

    pal_seq #(
        .IDX_W(IDX_W), .COMP_W(COMP_W), .NCOMP(NCOMP),
        .ENT_W(ENT_W), .BUS_W(BUS_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .commit_en(commit_en), .commit_data(commit_data),
        .wr_idx(wr_idx), .rd_idx(rd_idx),
        .fetch_data(fetch_data), .cnt(cnt)
    );

    pal_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_en), .wr_addr(wr_idx), .wr_data(commit_data),
        .fetch_addr(rd_idx), .fetch_data(fetch_data),
        .look_addr(pix_index), .look_data(pix_color)
    );
endmodule

// File: rtl/pal_dac_port_chk.sv
// Temporal checks on the palette port, bound to every instance of the top.
// Assumes synchronous active-low reset.
module pal_dac_port_chk #(
    parameter int IDX_W = 8,
    parameter int NCOMP = 3,
    parameter int CNT_W = 2,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic             host_re,
    input logic [3:0]       host_be,
    input logic [BUS_W-1:0] host_rdata,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] rd_idx,
    input logic [CNT_W-1:0] cnt,
    input logic             commit_en
);
    a_r3_index_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && (host_be[0] || host_be[3])) |=> (cnt == '0));

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) < NCOMP));

    a_r5_commit_steps_wr: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (cnt == '0));

    a_r6_third_read_steps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_we && int'(cnt) == NCOMP - 1)
        |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

    a_r10_both_strobes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_re) |=> $stable(host_rdata));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !host_re) |=> ($stable(host_rdata) && $stable(wr_idx)
                                    && $stable(rd_idx) && $stable(cnt)));
endmodule

bind pal_dac_port pal_dac_port_chk #(
    .IDX_W(IDX_W), .NCOMP(NCOMP), .CNT_W(CNT_W), .BUS_W(BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_be(host_be), .host_rdata(host_rdata), .wr_idx(wr_idx),
    .rd_idx(rd_idx), .cnt(cnt), .commit_en(commit_en)
);

// File: tb/pal_dac_port_test.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model compared on every clock,
// plus directed checks with hand-computed words.
module pal_dac_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [3:0]  host_be = 4'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_color;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;  // 125 MHz

    pal_dac_port uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_index(pix_index), .pix_color(pix_color)
    );

    // Reference model state.
    int          m_wr, m_rd, m_mask, m_cnt;
    int          m_hold [3];
    logic [23:0] m_ram [256];
    bit          m_val [256];
    logic [31:0] exp_rdata;
    logic [23:0] exp_pix;
    bit          pix_known;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model advances on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wr = 0; m_rd = 0; m_mask = 255; m_cnt = 0;
            foreach (m_hold[k]) m_hold[k] = 0;
            exp_rdata = '0; exp_pix = '0; pix_known = 1'b1;
        end else begin
            pix_known = m_val[pix_index];
            exp_pix   = m_ram[pix_index];
            if (host_we) begin
                bit idx_hit;
                idx_hit = host_be[0] || host_be[3];
                if (host_be[1] && !idx_hit) begin
                    m_hold[m_cnt] = host_wdata[15:8] & m_mask;
                    m_cnt++;
                    if (m_cnt == 3) begin
                        m_ram[m_wr] = {m_hold[0][7:0], m_hold[1][7:0], m_hold[2][7:0]};
                        m_val[m_wr] = 1'b1;
                        m_wr = (m_wr + 1) % 256;
                        m_cnt = 0;
                    end
                end
                if (host_be[0]) m_wr = host_wdata[7:0];
                if (host_be[3]) m_rd = host_wdata[31:24];
                if (idx_hit) m_cnt = 0;
                if (host_be[2]) m_mask = host_wdata[23:16];
            end else if (host_re) begin
                if (m_cnt == 0) begin
                    m_hold[0] = m_ram[m_rd][23:16];
                    m_hold[1] = m_ram[m_rd][15:8];
                    m_hold[2] = m_ram[m_rd][7:0];
                end
                exp_rdata = {m_rd[7:0], m_mask[7:0], m_hold[m_cnt][7:0], m_wr[7:0]};
                m_cnt++;
                if (m_cnt == 3) begin
                    m_rd = (m_rd + 1) % 256;
                    m_cnt = 0;
                end
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 R7 model host_rdata", host_rdata, exp_rdata);
            if (pix_known) chk("R9 model pix_color", {8'h0, pix_color}, {8'h0, exp_pix});
        end
    end

    task automatic acc(input bit we, input bit re, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_we = we; host_re = re; host_be = be; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0; host_be = 4'b0; host_wdata = '0;
    endtask

    task automatic set_widx(input logic [7:0] v); acc(1, 0, 4'b0001, {24'h0, v}); endtask
    task automatic set_ridx(input logic [7:0] v); acc(1, 0, 4'b1000, {v, 24'h0}); endtask
    task automatic set_mask(input logic [7:0] v); acc(1, 0, 4'b0100, {8'h0, v, 16'h0}); endtask
    task automatic put(input logic [7:0] v);      acc(1, 0, 4'b0010, {16'h0, v, 8'h0}); endtask
    task automatic get(input string tag, input logic [31:0] exp);
        acc(0, 1, 4'b0000, '0);
        chk(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read word", host_rdata, 32'h0);

        // R2 R5 R6: two entries streamed in, then read back in sequence.
        set_widx(8'h05);
        put(8'h11); put(8'h22); put(8'h33);
        put(8'h44); put(8'h55); put(8'h66);
        set_ridx(8'h05);
        get("R1 R6 R7 read red 5",   32'h05FF1107);
        get("R6 read green 5",       32'h05FF2207);
        get("R6 read blue 5",        32'h05FF3307);
        get("R5 R6 read red 6",      32'h06FF4407);
        get("R6 read green 6",       32'h06FF5507);
        get("R2 R6 read blue 6",     32'h06FF6607);

        // R4: masking of written data.
        set_mask(8'h0F);
        set_widx(8'h0A);
        put(8'hAB); put(8'hCD); put(8'hEF);
        set_ridx(8'h0A);
        get("R4 masked red",   32'h0A0F0B0B);
        get("R4 masked green", 32'h0A0F0D0B);
        get("R4 masked blue",  32'h0A0F0F0B);

        // R4: data and mask in one access use the old mask.
        set_widx(8'h14);
        acc(1, 0, 4'b0110, 32'h00F03C00);
        put(8'hFF); put(8'h5A);
        set_ridx(8'h14);
        get("R4 old mask applies", 32'h14F00C15);
        get("R4 new mask green",   32'h14F0F015);
        get("R4 new mask blue",    32'h14F05015);

        // R3: index write mid-entry restarts the counter, data lane ignored.
        set_mask(8'hFF);
        set_widx(8'h1E);
        put(8'h01);
        acc(1, 0, 4'b0011, 32'h0000991E);
        put(8'h41); put(8'h42); put(8'h43);
        set_ridx(8'h1E);
        get("R3 restart red",   32'h1EFF411F);
        get("R3 restart green", 32'h1EFF421F);
        get("R3 restart blue",  32'h1EFF431F);

        // R8: both indices wrap.
        set_widx(8'hFF);
        put(8'h01); put(8'h02); put(8'h03);
        put(8'h04); put(8'h05); put(8'h06);
        set_ridx(8'hFF);
        get("R8 entry 255 red",   32'hFFFF0101);
        get("R8 entry 255 green", 32'hFFFF0201);
        get("R8 entry 255 blue",  32'hFFFF0301);
        get("R8 wrapped red",     32'h00FF0401);
        get("R8 wrapped green",   32'h00FF0501);
        get("R8 wrapped blue",    32'h00FF0601);

        // R10: both strobes, then idle.
        acc(1, 1, 4'b0001, 32'h0000004D);
        chk("R10 both strobes hold rdata", host_rdata, 32'h00FF0601);
        repeat (2) @(negedge clk);
        chk("R10 idle holds rdata", host_rdata, 32'h00FF0601);
        set_ridx(8'h05);
        get("R10 write applied", 32'h05FF114D);

        // R9: display lookup port.
        pix_index = 8'h0A;
        @(negedge clk);
        chk("R9 lookup 10", {8'h0, pix_color}, 32'h000B0D0F);
        pix_index = 8'hFF;
        @(negedge clk);
        chk("R9 lookup 255", {8'h0, pix_color}, 32'h00010203);
        pix_index = 8'h00;
        @(negedge clk);
        chk("R8 R9 lookup 0", {8'h0, pix_color}, 32'h00040506);

        // R9: commit at the same edge as the lookup is seen one clock later.
        pix_index = 8'h05;
        set_widx(8'h05);
        put(8'h77); put(8'h88); put(8'h99);
        chk("R9 same edge old value", {8'h0, pix_color}, 32'h00112233);
        @(negedge clk);
        chk("R9 next edge new value", {8'h0, pix_color}, 32'h00778899);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule